// File: doc/BRIEF.md
# ATA Task File Shadow Registers

This block holds the legacy command and control registers that host software sees when it drives a serial ATA drive through a parallel-IDE style I/O window. The host reaches it through a byte-wide port with an address, a write strobe, a read strobe and a data byte. The sector count, feature and three LBA registers are each one byte wide at the port. Each of them keeps the last two bytes written, so that a 48-bit LBA command can be set up through 8-bit registers.

Bit 7 of the device control byte selects which of the two stored bytes a read returns. A write to the command register captures every shadow value into a 20-byte host-to-device register frame, presented as one parallel word together with a single-cycle valid strobe. Link and transport layers, CRC, DMA, the PIO data port, interrupts and hot plug are handled elsewhere.

Top module: `ata_shadow_tf`

## Requirements
- R1: A synchronous active-high reset clears every stored byte, the device register and the control byte to zero, drives `fis_valid` low and `hst_rdata` to zero.
- R2: A write to the feature (offset 1), sector count (offset 2), LBA low (offset 3), LBA mid (offset 4) or LBA high (offset 5) register moves that register's newest byte into its older slot and stores the written byte as newest.
- R3: With control bit 7 at 0, a read of offsets 2 to 5 returns the newest byte of that register one clock after the read strobe is sampled.
- R4: With control bit 7 at 1, a read of offsets 2 to 5 returns the older byte of that register.
- R5: A write to the control address shifts no register and changes no stored byte.
- R6: A control write with bit 2 set clears both bytes of all five two-byte registers.
- R7: A write to the command register (offset 7) raises `fis_valid` for exactly one cycle, in the cycle after the write is sampled.
- R8: The frame has byte k at `fis_data[8k+7:8k]`. Byte 0 is 27h, byte 1 is 80h, byte 2 is the command, bytes 3/4/5/6 are the newest feature/LBA low/mid/high, byte 7 is the device, bytes 8/9/10 are the older LBA low/mid/high, byte 11 is the older feature, bytes 12/13 are the newest/older sector count, byte 15 is the control byte, and bytes 14 and 16 to 19 are zero.
- R9: Reads of offset 7 and of the control address return `dev_status`, a read of offset 1 returns `dev_error`, and none of these reads changes any stored byte.
- R10: With `PRIMARY`=1 the block decodes 1F0h-1F7h and 3F6h; with `PRIMARY`=0 it decodes 170h-177h and 376h. Writes to the other channel's addresses change nothing.
- R11: The device register (offset 6) is a single byte: a read returns the last byte written, whatever control bit 7 is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_addr | input | ADDR_W | Host I/O address |
| hst_wr | input | 1 | Host write strobe, one byte per cycle |
| hst_rd | input | 1 | Host read strobe |
| hst_wdata | input | 8 | Host write byte |
| hst_rdata | output | 8 | Registered read byte, valid the cycle after the read strobe |
| dev_status | input | 8 | Status byte from the device side |
| dev_error | input | 8 | Error byte from the device side |
| fis_valid | output | 1 | One-cycle strobe marking a new register frame |
| fis_data | output | 160 | Host-to-device register frame, byte 0 in the low bits |

## Verification
Every result is one register stage from its stimulus. A read byte appears on `hst_rdata` after the clock edge that samples the read strobe, and the frame and its strobe appear after the edge that samples the command write. The bench drives strobes at falling edges and samples at the next falling edge, half a cycle after the capturing edge. The strobe is checked again one falling edge later to confirm that it has dropped. A stored byte is only seen through a later read, so each ignored write or side-effect-free read is followed by a read-back of the register it might have disturbed.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;

    localparam int BYTE_W    = 8;
    localparam int FIS_BYTES = 20;
    localparam int FIS_W     = FIS_BYTES * BYTE_W;
    localparam int N_FIFO    = 5;
    localparam int FIDX_W    = $clog2(N_FIFO);

    localparam logic [7:0] FIS_TYPE_H2D = 8'h27;
    localparam logic [7:0] FIS_FLAG_CMD = 8'h80;

    localparam int CTL_HOB_BIT  = 7;
    localparam int CTL_SRST_BIT = 2;

    // command block offsets
    typedef enum logic [2:0] {
        OFS_DATA    = 3'd0,
        OFS_ERRFEAT = 3'd1,
        OFS_COUNT   = 3'd2,
        OFS_LBA_LO  = 3'd3,
        OFS_LBA_MID = 3'd4,
        OFS_LBA_HI  = 3'd5,
        OFS_DEVICE  = 3'd6,
        OFS_STSCMD  = 3'd7
    } cmd_ofs_e;

    // index of each two-byte register; index = offset - 1
    typedef enum logic [FIDX_W-1:0] {
        FQ_FEAT    = 3'd0,
        FQ_COUNT   = 3'd1,
        FQ_LBA_LO  = 3'd2,
        FQ_LBA_MID = 3'd3,
        FQ_LBA_HI  = 3'd4
    } fq_idx_e;

    typedef enum logic [2:0] {
        RD_NONE,
        RD_ZERO,
        RD_ERR,
        RD_STS,
        RD_DEV,
        RD_FIFO
    } rd_src_e;

    typedef struct packed {
        logic [BYTE_W-1:0] cur;
        logic [BYTE_W-1:0] prev;
    } byte_pair_t;

    typedef struct packed {
        byte_pair_t        feat;
        byte_pair_t        count;
        byte_pair_t        lba_lo;
        byte_pair_t        lba_mid;
        byte_pair_t        lba_hi;
        logic [BYTE_W-1:0] device;
        logic [BYTE_W-1:0] control;
    } shadow_t;

    function automatic logic [FIDX_W-1:0] fifo_of_offset(logic [2:0] ofs);
        return FIDX_W'(ofs - 3'd1);
    endfunction

    function automatic logic [FIS_W-1:0] pack_h2d(shadow_t s, logic [BYTE_W-1:0] cmd);
        logic [BYTE_W-1:0] b [FIS_BYTES];
        logic [FIS_W-1:0]  w;
        for (int i = 0; i < FIS_BYTES; i++) b[i] = '0;
        b[0]  = FIS_TYPE_H2D;
        b[1]  = FIS_FLAG_CMD;
        b[2]  = cmd;
        b[3]  = s.feat.cur;
        b[4]  = s.lba_lo.cur;
        b[5]  = s.lba_mid.cur;
        b[6]  = s.lba_hi.cur;
        b[7]  = s.device;
        b[8]  = s.lba_lo.prev;
        b[9]  = s.lba_mid.prev;
        b[10] = s.lba_hi.prev;
        b[11] = s.feat.prev;
        b[12] = s.count.cur;
        b[13] = s.count.prev;
        b[15] = s.control;
        w = '0;
        for (int i = 0; i < FIS_BYTES; i++) w[i*BYTE_W +: BYTE_W] = b[i];
        return w;
    endfunction

endpackage

// File: rtl/tf_addr_decode.sv
module tf_addr_decode
    import ata_tf_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter bit PRIMARY = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output logic [N_FIFO-1:0] fifo_wr,
    output logic              dev_wr,
    output logic              cmd_wr,
    output logic              ctl_wr,
    output rd_src_e           rd_src,
    output logic [FIDX_W-1:0] rd_fifo
);

    localparam logic [ADDR_W-1:0] CMD_BASE = PRIMARY ? ADDR_W'(16'h01F0) : ADDR_W'(16'h0170);
    localparam logic [ADDR_W-1:0] CTL_ADDR = PRIMARY ? ADDR_W'(16'h03F6) : ADDR_W'(16'h0376);

    logic       cmd_hit;
    logic       ctl_hit;
    logic [2:0] ofs;

    assign ofs     = addr[2:0];
    assign cmd_hit = (addr[ADDR_W-1:3] == CMD_BASE[ADDR_W-1:3]);
    assign ctl_hit = (addr == CTL_ADDR);

    for (genvar g = 0; g < N_FIFO; g++) begin : g_fwr
        assign fifo_wr[g] = wr && cmd_hit && (ofs == 3'(g + 1));
    end

    assign dev_wr  = wr && cmd_hit && (ofs == OFS_DEVICE);
    assign cmd_wr  = wr && cmd_hit && (ofs == OFS_STSCMD);
    assign ctl_wr  = wr && ctl_hit;
    assign rd_fifo = fifo_of_offset(ofs);

    always_comb begin
        rd_src = RD_NONE;
        if (rd && ctl_hit) begin
            rd_src = RD_STS;
        end else if (rd && cmd_hit) begin
            case (cmd_ofs_e'(ofs))
                OFS_DATA:    rd_src = RD_ZERO;
                OFS_ERRFEAT: rd_src = RD_ERR;
                OFS_DEVICE:  rd_src = RD_DEV;
                OFS_STSCMD:  rd_src = RD_STS;
                default:     rd_src = RD_FIFO;
            endcase
        end
    end

endmodule

// File: rtl/tf_byte_fifo2.sv
module tf_byte_fifo2
    import ata_tf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] din,
    input  logic              hob,
    output byte_pair_t        q,
    output logic [BYTE_W-1:0] rd_byte
);

    byte_pair_t q_r;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            q_r <= '0;
        end else if (wr_en) begin
            q_r.prev <= q_r.cur;
            q_r.cur  <= din;
        end
    end

    assign q       = q_r;
    assign rd_byte = hob ? q_r.prev : q_r.cur;

    p_shift_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !clr) |=> (q.prev == $past(q.cur)) && (q.cur == $past(din)));

    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !clr) |=> $stable(q));

    p_clear_r6: assert property (@(posedge clk) disable iff (rst)
        clr |=> (q == '0));

endmodule

// File: rtl/tf_fis_build.sv
module tf_fis_build
    import ata_tf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  shadow_t           shadow,
    input  logic [BYTE_W-1:0] cmd,
    output logic              fis_valid,
    output logic [FIS_W-1:0]  fis_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            fis_valid <= 1'b0;
            fis_data  <= '0;
        end else begin
            fis_valid <= fire;
            if (fire) fis_data <= pack_h2d(shadow, cmd);
        end
    end

    p_hdr_r8: assert property (@(posedge clk) disable iff (rst)
        fis_valid |-> (fis_data[7:0] == FIS_TYPE_H2D) && (fis_data[15:8] == FIS_FLAG_CMD)
                      && (fis_data[FIS_W-1:16*BYTE_W] == '0));

endmodule

// File: rtl/ata_shadow_tf.sv
module ata_shadow_tf
    import ata_tf_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter bit PRIMARY = 1'b1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [ADDR_W-1:0]           hst_addr,
    input  logic                        hst_wr,
    input  logic                        hst_rd,
    input  logic [7:0]                  hst_wdata,
    output logic [7:0]                  hst_rdata,
    input  logic [7:0]                  dev_status,
    input  logic [7:0]                  dev_error,
    output logic                        fis_valid,
    output logic [ata_tf_pkg::FIS_W-1:0] fis_data
);

    localparam logic [ADDR_W-1:0] CMD_REG = PRIMARY ? ADDR_W'(16'h01F7) : ADDR_W'(16'h0177);

    logic [N_FIFO-1:0] fifo_wr;
    logic              dev_wr;
    logic              cmd_wr;
    logic              ctl_wr;
    rd_src_e           rd_src;
    logic [FIDX_W-1:0] rd_fifo;

    logic [BYTE_W-1:0] ctl_q;
    logic [BYTE_W-1:0] dev_q;
    logic              hob;
    logic              srst_clr;

    byte_pair_t        fq    [N_FIFO];
    logic [BYTE_W-1:0] fq_rd [N_FIFO];
    shadow_t           shadow;

    tf_addr_decode #(.ADDR_W(ADDR_W), .PRIMARY(PRIMARY)) u_dec (
        .addr    (hst_addr),
        .wr      (hst_wr),
        .rd      (hst_rd),
        .fifo_wr (fifo_wr),
        .dev_wr  (dev_wr),
        .cmd_wr  (cmd_wr),
        .ctl_wr  (ctl_wr),
        .rd_src  (rd_src),
        .rd_fifo (rd_fifo)
    );

    assign hob      = ctl_q[CTL_HOB_BIT];
    assign srst_clr = ctl_wr && hst_wdata[CTL_SRST_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            dev_q <= '0;
        end else begin
            if (ctl_wr) ctl_q <= hst_wdata;
            if (dev_wr) dev_q <= hst_wdata;
        end
    end

    for (genvar g = 0; g < N_FIFO; g++) begin : g_fifo
        tf_byte_fifo2 u_fifo (
            .clk     (clk),
            .rst     (rst),
            .clr     (srst_clr),
            .wr_en   (fifo_wr[g]),
            .din     (hst_wdata),
            .hob     (hob),
            .q       (fq[g]),
            .rd_byte (fq_rd[g])
        );
    end

    always_comb begin
        shadow         = '0;
        shadow.feat    = fq[FQ_FEAT];
        shadow.count   = fq[FQ_COUNT];
        shadow.lba_lo  = fq[FQ_LBA_LO];
        shadow.lba_mid = fq[FQ_LBA_MID];
        shadow.lba_hi  = fq[FQ_LBA_HI];
        shadow.device  = dev_q;
        shadow.control = ctl_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hst_rdata <= '0;
        end else begin
            case (rd_src)
                RD_ZERO: hst_rdata <= '0;
                RD_ERR:  hst_rdata <= dev_error;
                RD_STS:  hst_rdata <= dev_status;
                RD_DEV:  hst_rdata <= dev_q;
                RD_FIFO: hst_rdata <= fq_rd[rd_fifo];
                default: hst_rdata <= hst_rdata;
            endcase
        end
    end

    tf_fis_build u_fis (
        .clk       (clk),
        .rst       (rst),
        .fire      (cmd_wr),
        .shadow    (shadow),
        .cmd       (hst_wdata),
        .fis_valid (fis_valid),
        .fis_data  (fis_data)
    );

    p_fis_cause_r7: assert property (@(posedge clk) disable iff (rst)
        fis_valid |-> $past(hst_wr && (hst_addr == CMD_REG)));

    p_hob_read_r4: assert property (@(posedge clk) disable iff (rst)
        $past(hst_rd && (rd_src == RD_FIFO) && hob) |-> (hst_rdata == $past(fq[rd_fifo].prev)));

    p_new_read_r3: assert property (@(posedge clk) disable iff (rst)
        $past(hst_rd && (rd_src == RD_FIFO) && !hob) |-> (hst_rdata == $past(fq[rd_fifo].cur)));

endmodule

// File: tb/ata_shadow_tf_bench.sv
module ata_shadow_tf_bench;

    logic         clk = 1'b0;
    logic         rst;
    logic [15:0]  hst_addr;
    logic         hst_wr;
    logic         hst_rd;
    logic [7:0]   hst_wdata;
    logic [7:0]   hst_rdata;
    logic [7:0]   dev_status;
    logic [7:0]   dev_error;
    logic         fis_valid;
    logic [159:0] fis_data;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    ata_shadow_tf u_ata_shadow_tf (
        .clk        (clk),
        .rst        (rst),
        .hst_addr   (hst_addr),
        .hst_wr     (hst_wr),
        .hst_rd     (hst_rd),
        .hst_wdata  (hst_wdata),
        .hst_rdata  (hst_rdata),
        .dev_status (dev_status),
        .dev_error  (dev_error),
        .fis_valid  (fis_valid),
        .fis_data   (fis_data)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FIL-%s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        hst_addr = a; hst_wdata = d; hst_wr = 1'b1;
        @(negedge clk);
        hst_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        hst_addr = a; hst_rd = 1'b1;
        @(negedge clk);
        hst_rd = 1'b0;
        d = hst_rdata;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1 rdata", hst_rdata, 8'h00);
        chk("R1 valid", {7'b0, fis_valid}, 8'h00);
        for (int a = 16'h1F2; a <= 16'h1F5; a++) begin
            rd(16'(a), v); chk("R1 newest", v, 8'h00);
        end
        wr(16'h03F6, 8'h80);
        for (int a = 16'h1F2; a <= 16'h1F5; a++) begin
            rd(16'(a), v); chk("R1 older", v, 8'h00);
        end
        wr(16'h03F6, 8'h00);
    endtask

    task automatic t_order();
        logic [7:0] v;
        wr(16'h01F3, 8'h11); wr(16'h01F3, 8'h22);
        wr(16'h01F4, 8'h33); wr(16'h01F4, 8'h44);
        wr(16'h01F5, 8'h55); wr(16'h01F5, 8'h66);
        wr(16'h01F2, 8'h77); wr(16'h01F2, 8'h88);
        rd(16'h01F3, v); chk("R3 lba lo", v, 8'h22);
        rd(16'h01F4, v); chk("R3 lba mid", v, 8'h44);
        rd(16'h01F5, v); chk("R3 lba hi", v, 8'h66);
        rd(16'h01F2, v); chk("R3 count", v, 8'h88);
        wr(16'h03F6, 8'h80);
        rd(16'h01F3, v); chk("R4 lba lo", v, 8'h11);
        rd(16'h01F4, v); chk("R4 lba mid", v, 8'h33);
        rd(16'h01F5, v); chk("R4 lba hi", v, 8'h55);
        rd(16'h01F2, v); chk("R4 count", v, 8'h77);
        wr(16'h03F6, 8'h80);
        wr(16'h03F6, 8'h00);
        rd(16'h01F3, v); chk("R5 newest kept", v, 8'h22);
        wr(16'h03F6, 8'h80);
        rd(16'h01F3, v); chk("R5 older kept", v, 8'h11);
        wr(16'h01F3, 8'h99);
        rd(16'h01F3, v); chk("R2 shifted", v, 8'h22);
        wr(16'h03F6, 8'h00);
        rd(16'h01F3, v); chk("R2 new", v, 8'h99);
    endtask

    task automatic t_device();
        logic [7:0] v;
        wr(16'h01F6, 8'hA5);
        rd(16'h01F6, v); chk("R11 hob0", v, 8'hA5);
        wr(16'h03F6, 8'h80);
        rd(16'h01F6, v); chk("R11 hob1", v, 8'hA5);
        wr(16'h03F6, 8'h00);
    endtask

    task automatic t_status();
        logic [7:0] v;
        dev_status = 8'h50; dev_error = 8'h04;
        rd(16'h01F7, v); chk("R9 status", v, 8'h50);
        rd(16'h01F1, v); chk("R9 error", v, 8'h04);
        rd(16'h03F6, v); chk("R9 alt status", v, 8'h50);
        rd(16'h01F3, v); chk("R9 fifo intact", v, 8'h99);
        rd(16'h01F3, v); chk("R9 fifo intact again", v, 8'h99);
    endtask

    task automatic t_fis();
        logic [7:0] exp [20];
        wr(16'h01F1, 8'hA1); wr(16'h01F1, 8'hA2);
        wr(16'h01F2, 8'h01); wr(16'h01F2, 8'h02);
        wr(16'h01F3, 8'h10); wr(16'h01F3, 8'h20);
        wr(16'h01F4, 8'h30); wr(16'h01F4, 8'h40);
        wr(16'h01F5, 8'h50); wr(16'h01F5, 8'h60);
        wr(16'h01F6, 8'hE0);
        wr(16'h03F6, 8'h02);
        chk("R7 idle before", {7'b0, fis_valid}, 8'h00);
        wr(16'h01F7, 8'h24);
        chk("R7 strobe", {7'b0, fis_valid}, 8'h01);
        for (int i = 0; i < 20; i++) exp[i] = 8'h00;
        exp[0] = 8'h27; exp[1] = 8'h80; exp[2] = 8'h24; exp[3] = 8'hA2;
        exp[4] = 8'h20; exp[5] = 8'h40; exp[6] = 8'h60; exp[7] = 8'hE0;
        exp[8] = 8'h10; exp[9] = 8'h30; exp[10] = 8'h50; exp[11] = 8'hA1;
        exp[12] = 8'h02; exp[13] = 8'h01; exp[15] = 8'h02;
        for (int i = 0; i < 20; i++) chk($sformatf("R8 byte %0d", i), fis_data[8*i +: 8], exp[i]);
        @(negedge clk);
        chk("R7 single cycle", {7'b0, fis_valid}, 8'h00);
    endtask

    task automatic t_srst();
        logic [7:0] v;
        wr(16'h03F6, 8'h04);
        rd(16'h01F3, v); chk("R6 newest cleared", v, 8'h00);
        wr(16'h03F6, 8'h80);
        rd(16'h01F5, v); chk("R6 older cleared", v, 8'h00);
        wr(16'h03F6, 8'h00);
        wr(16'h01F7, 8'hEC);
        chk("R6 frame feature", fis_data[8*3 +: 8], 8'h00);
        chk("R6 frame ext count", fis_data[8*13 +: 8], 8'h00);
    endtask

    task automatic t_channel();
        logic [7:0] v;
        wr(16'h01F3, 8'h01); wr(16'h01F3, 8'h02);
        wr(16'h0173, 8'h5A);
        wr(16'h0376, 8'h84);
        wr(16'h0177, 8'hC8);
        rd(16'h01F3, v); chk("R10 other base ignored", v, 8'h02);
        chk("R10 no frame", {7'b0, fis_valid}, 8'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; hst_addr = '0; hst_wr = 1'b0; hst_rd = 1'b0; hst_wdata = '0;
        dev_status = '0; dev_error = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_order();
        t_device();
        t_status();
        t_fis();
        t_srst();
        t_channel();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule